// File: doc/BRIEF.md
# NAND bus access timing controller

This block converts one host read or write request at a time into a timed strobe sequence on an 8-bit NAND flash bus. Every access passes through a setup phase, a strobe-active (wait) phase and a hold phase. Each phase length comes from its own 8-bit field and lasts the field value plus one clock. On writes, a fourth field sets how long the data bus is driven, counted from the start of the access.

Command and address cycles have no registers of their own. Two host address bits pick the region, and so they pick whether a write raises the command latch line, the address latch line, or neither. A ready/wait input can stretch the strobe phase when stretching is enabled. The chip enable falls on the first accepted request and stays low between accesses. It is released only when the host reports an access to another bank while this block is idle.

Top module: `nand_bus_timer`

## Requirements
- R1: While reset is high, and in the cycle after it, nand_ce_n, nand_we_n and nand_oe_n are 1 and nand_cle, nand_ale, nand_doe and done are 0.
- R2: A request is accepted on an idle clock edge. In the next cycle nand_ce_n is 0, and both strobes stay high for set_cyc+1 cycles, which form the setup phase.
- R3: After setup, the wait phase lasts wait_cyc+1 cycles. nand_we_n is 0 during it on a write and nand_oe_n is 0 during it on a read. The other strobe stays 1 for the whole access.
- R4: A hold phase of hold_cyc+1 cycles follows, with both strobes high. Then done is 1 for exactly one cycle, and the block is idle in that cycle.
- R5: On a write, nand_doe is 1 for hiz_cyc+1 cycles counted from the first setup cycle. It is cut short no later than the done cycle. nand_dout carries the write data while nand_doe is 1. On a read, nand_doe stays 0.
- R6: On a write, region bit 0 (host address bit 16) raises nand_cle. Region bit 1 (host address bit 17) raises nand_ale only when bit 0 is clear, so the command line takes priority. The selected line is held from the first setup cycle to the last hold cycle. On a read, both lines stay 0.
- R7: On a read, rdata takes nand_din at the edge that ends the wait phase and keeps that value afterwards.
- R8: When wait_en is 1, each edge in the wait phase that sees nand_rdy at 0 adds one cycle to the wait phase. When wait_en is 0, nand_rdy has no effect.
- R9: nand_ce_n stays 0 between accesses. If other_bank is 1 on an idle edge with no request, nand_ce_n is 1 from the next cycle on. During an access, other_bank is ignored.
- R10: A request during an access is ignored. The timing fields are taken at the accepting edge, so changing them during an access does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host access request, taken when idle |
| wr | input | 1 | 1 = write, 0 = read |
| region | input | 2 | Host address bits 17:16: bit 0 command, bit 1 address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data captured at end of wait phase |
| done | output | 1 | One-cycle pulse after the hold phase |
| set_cyc | input | FIELD_W | Setup length minus one |
| wait_cyc | input | FIELD_W | Strobe phase length minus one |
| hold_cyc | input | FIELD_W | Hold length minus one |
| hiz_cyc | input | FIELD_W | Write bus-drive length minus one |
| wait_en | input | 1 | Lets nand_rdy stretch the wait phase |
| other_bank | input | 1 | Host reports an access to another bank |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_oe_n | output | 1 | Read strobe, active low |
| nand_dout | output | DATA_W | Data driven toward the flash |
| nand_doe | output | 1 | Output enable for nand_dout |
| nand_din | input | DATA_W | Data read from the flash |
| nand_rdy | input | 1 | Ready/wait from the flash, low = busy |

## Verification
All outputs are registered. Chip enable, the latch lines and the output enable therefore change in the first cycle after the accepting edge. The strobe falls set_cyc+1 cycles after that and rises wait_cyc+1 unstalled cycles later. done follows the last hold cycle by one cycle, and rdata changes in the first hold cycle. The reference model in the bench counts these windows with plain integers, including each stalled cycle it creates with nand_rdy. Inputs are driven and outputs are compared on the falling clock edge of every cycle, so each sample sees the values registered at the preceding rising edge.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_WAIT  = 2'd2,
    PH_HOLD  = 2'd3
  } phase_t;
endpackage

// File: rtl/nbt_phase_seq.sv
module nbt_phase_seq
  import nbt_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic [FIELD_W-1:0] set_f,
  input  logic [FIELD_W-1:0] wait_f,
  input  logic [FIELD_W-1:0] hold_f,
  input  logic               wait_en,
  input  logic               rdy,
  output phase_t             ph,
  output phase_t             ph_nxt,
  output logic               accept,
  output logic               wait_last,
  output logic               hold_last
);
  logic [FIELD_W-1:0] cnt, cnt_nxt;
  logic [FIELD_W-1:0] wait_q, hold_q;
  logic               stall;

  always_comb begin
    stall     = wait_en && !rdy;
    accept    = (ph == PH_IDLE) && req;
    wait_last = (ph == PH_WAIT) && !stall && (cnt == '0);
    hold_last = (ph == PH_HOLD) && (cnt == '0);
    ph_nxt    = ph;
    cnt_nxt   = cnt;
    unique case (ph)
      PH_IDLE: begin
        if (req) begin
          ph_nxt  = PH_SETUP;
          cnt_nxt = set_f;
        end
      end
      PH_SETUP: begin
        if (cnt == '0) begin
          ph_nxt  = PH_WAIT;
          cnt_nxt = wait_q;
        end else begin
          cnt_nxt = cnt - 1'b1;
        end
      end
      PH_WAIT: begin
        if (!stall) begin
          if (cnt == '0) begin
            ph_nxt  = PH_HOLD;
            cnt_nxt = hold_q;
          end else begin
            cnt_nxt = cnt - 1'b1;
          end
        end
      end
      PH_HOLD: begin
        if (cnt == '0) ph_nxt = PH_IDLE;
        else           cnt_nxt = cnt - 1'b1;
      end
      default: ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      wait_q <= '0;
      hold_q <= '0;
    end else begin
      ph  <= ph_nxt;
      cnt <= cnt_nxt;
      if (accept) begin
        wait_q <= wait_f;
        hold_q <= hold_f;
      end
    end
  end
endmodule

// File: rtl/nbt_pin_drv.sv
module nbt_pin_drv
  import nbt_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  phase_t             ph_nxt,
  input  logic               accept,
  input  logic               wait_last,
  input  logic               hold_last,
  input  logic               wr,
  input  logic               cle_sel,
  input  logic               ale_sel,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [FIELD_W-1:0] hiz_f,
  input  logic [DATA_W-1:0]  din,
  output logic               we_n,
  output logic               oe_n,
  output logic               cle,
  output logic               ale,
  output logic               doe,
  output logic [DATA_W-1:0]  dout,
  output logic [DATA_W-1:0]  rdata,
  output logic               done
);
  logic               wr_q, cmd_q, adr_q;
  logic               wr_n, cmd_n, adr_n, busy_n, strobe_n;
  logic [FIELD_W-1:0] drive_left;

  always_comb begin
    wr_n     = accept ? wr : wr_q;
    cmd_n    = accept ? (wr && cle_sel) : cmd_q;
    adr_n    = accept ? (wr && ale_sel && !cle_sel) : adr_q;
    busy_n   = (ph_nxt != PH_IDLE);
    strobe_n = (ph_nxt == PH_WAIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q       <= 1'b0;
      cmd_q      <= 1'b0;
      adr_q      <= 1'b0;
      we_n       <= 1'b1;
      oe_n       <= 1'b1;
      cle        <= 1'b0;
      ale        <= 1'b0;
      doe        <= 1'b0;
      dout       <= '0;
      rdata      <= '0;
      done       <= 1'b0;
      drive_left <= '0;
    end else begin
      wr_q  <= wr_n;
      cmd_q <= cmd_n;
      adr_q <= adr_n;
      we_n  <= !(strobe_n && wr_n);
      oe_n  <= !(strobe_n && !wr_n);
      cle   <= busy_n && cmd_n;
      ale   <= busy_n && adr_n;
      done  <= hold_last;
      if (wait_last && !wr_q) rdata <= din;
      if (accept) begin
        dout       <= wdata;
        doe        <= wr;
        drive_left <= hiz_f;
      end else if (!busy_n) begin
        doe <= 1'b0;
      end else if (doe) begin
        if (drive_left == '0) doe <= 1'b0;
        else                  drive_left <= drive_left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/nbt_ce_hold.sv
module nbt_ce_hold (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic idle,
  input  logic other_bank,
  output logic ce_n
);
  always_ff @(posedge clk) begin
    if (rst)                      ce_n <= 1'b1;
    else if (accept)              ce_n <= 1'b0;
    else if (idle && other_bank)  ce_n <= 1'b1;
  end
endmodule

// File: rtl/nand_bus_timer.sv
module nand_bus_timer
  import nbt_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic               wr,
  input  logic [1:0]         region,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               done,
  input  logic [FIELD_W-1:0] set_cyc,
  input  logic [FIELD_W-1:0] wait_cyc,
  input  logic [FIELD_W-1:0] hold_cyc,
  input  logic [FIELD_W-1:0] hiz_cyc,
  input  logic               wait_en,
  input  logic               other_bank,
  output logic               nand_ce_n,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic               nand_oe_n,
  output logic [DATA_W-1:0]  nand_dout,
  output logic               nand_doe,
  input  logic [DATA_W-1:0]  nand_din,
  input  logic               nand_rdy
);
  phase_t ph, ph_nxt;
  logic   accept, wait_last, hold_last, idle;

  assign idle = (ph == PH_IDLE);

  nbt_phase_seq #(.FIELD_W(FIELD_W)) u_seq (
    .clk(clk), .rst(rst), .req(req),
    .set_f(set_cyc), .wait_f(wait_cyc), .hold_f(hold_cyc),
    .wait_en(wait_en), .rdy(nand_rdy),
    .ph(ph), .ph_nxt(ph_nxt), .accept(accept),
    .wait_last(wait_last), .hold_last(hold_last)
  );

  nbt_pin_drv #(.FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst), .ph_nxt(ph_nxt), .accept(accept),
    .wait_last(wait_last), .hold_last(hold_last), .wr(wr),
    .cle_sel(region[0]), .ale_sel(region[1]), .wdata(wdata),
    .hiz_f(hiz_cyc), .din(nand_din),
    .we_n(nand_we_n), .oe_n(nand_oe_n), .cle(nand_cle), .ale(nand_ale),
    .doe(nand_doe), .dout(nand_dout), .rdata(rdata), .done(done)
  );

  nbt_ce_hold u_ce (
    .clk(clk), .rst(rst), .accept(accept), .idle(idle),
    .other_bank(other_bank), .ce_n(nand_ce_n)
  );
endmodule

// File: rtl/nbt_checker.sv
module nbt_checker (
  input logic clk,
  input logic rst,
  input logic wait_en,
  input logic nand_rdy,
  input logic nand_we_n,
  input logic nand_oe_n,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_doe,
  input logic done
);
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_oe_n));

  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_no_read_drive_r5: assert property (@(posedge clk) disable iff (rst)
    !nand_oe_n |-> !nand_doe);

  p_latch_no_read_r6: assert property (@(posedge clk) disable iff (rst)
    (nand_cle || nand_ale) |-> nand_oe_n);

  p_stall_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (wait_en && !nand_rdy && (!nand_we_n || !nand_oe_n)) |=> (!nand_we_n || !nand_oe_n));

  p_ce_on_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n || !nand_oe_n) |-> !nand_ce_n);
endmodule

bind nand_bus_timer nbt_checker u_chk (
  .clk(clk), .rst(rst), .wait_en(wait_en), .nand_rdy(nand_rdy),
  .nand_we_n(nand_we_n), .nand_oe_n(nand_oe_n), .nand_ce_n(nand_ce_n),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_doe(nand_doe), .done(done)
);

// File: tb/nand_bus_timer_test.sv
module nand_bus_timer_test;
  logic       clk = 1'b0;
  logic       rst, req, wr, wait_en, other_bank, nand_rdy;
  logic [1:0] region;
  logic [7:0] wdata, set_cyc, wait_cyc, hold_cyc, hiz_cyc, nand_din;
  logic [7:0] rdata, nand_dout;
  logic       done, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_oe_n, nand_doe;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;  // 4 ns period

  nand_bus_timer uut (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .region(region), .wdata(wdata),
    .rdata(rdata), .done(done), .set_cyc(set_cyc), .wait_cyc(wait_cyc),
    .hold_cyc(hold_cyc), .hiz_cyc(hiz_cyc), .wait_en(wait_en),
    .other_bank(other_bank), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_oe_n(nand_oe_n),
    .nand_dout(nand_dout), .nand_doe(nand_doe), .nand_din(nand_din),
    .nand_rdy(nand_rdy)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic busy_check(input bit w, input int c, input int z, input int wd,
                            input bit cmd, input bit adr, input bit strobe, input string tag);
    bit exp_doe;
    exp_doe = w && (c <= z);
    chk("R9", "ce_n", nand_ce_n, 0);
    chk("R4", "done", done, 0);
    chk(tag, "we_n", nand_we_n, (strobe && w) ? 0 : 1);
    chk(tag, "oe_n", nand_oe_n, (strobe && !w) ? 0 : 1);
    chk("R6", "cle", nand_cle, cmd);
    chk("R6", "ale", nand_ale, adr);
    chk("R5", "doe", nand_doe, exp_doe);
    if (exp_doe) chk("R5", "dout", nand_dout, wd);
  endtask

  // One access through the reference model; returns in the done cycle.
  task automatic do_acc(input bit w, input int reg_bits, input int wd, input int rv,
                        input int s, input int wt, input int h, input int z,
                        input bit wen, input int stalls, input bit noise);
    int  c = 0;
    int  counted = 0;
    int  left = stalls;
    bit  cmd, adr;
    cmd = w && reg_bits[0];
    adr = w && reg_bits[1] && !reg_bits[0];
    @(negedge clk);
    req = 1'b1; wr = w; region = reg_bits[1:0]; wdata = wd[7:0];
    set_cyc = s[7:0]; wait_cyc = wt[7:0]; hold_cyc = h[7:0]; hiz_cyc = z[7:0];
    wait_en = wen; nand_din = rv[7:0]; nand_rdy = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i <= s; i++) begin
      busy_check(w, c, z, wd, cmd, adr, 1'b0, "R2");
      if (noise) begin  // R10 / R9: ignored while busy
        req = 1'b1; other_bank = 1'b1; wr = !w; region = 2'b11;
        set_cyc = 8'd9; wait_cyc = 8'd9; hold_cyc = 8'd9; hiz_cyc = 8'd0;
      end
      c++;
      @(negedge clk);
    end
    req = 1'b0; other_bank = 1'b0;
    while (counted < wt + 1) begin
      busy_check(w, c, z, wd, cmd, adr, 1'b1, noise ? "R10" : "R3");
      if (left > 0) begin
        nand_rdy = 1'b0;
        left--;
        if (!wen) counted++;  // R8: ready ignored
      end else begin
        nand_rdy = 1'b1;
        counted++;
      end
      c++;
      @(negedge clk);
    end
    nand_rdy = 1'b1;
    nand_din = ~rv[7:0];
    for (int i = 0; i <= h; i++) begin
      busy_check(w, c, z, wd, cmd, adr, 1'b0, "R4");
      if (!w) chk("R7", "rdata", rdata, rv & 8'hff);
      c++;
      @(negedge clk);
    end
    chk("R4", "done pulse", done, 1);
    chk("R4", "we_n idle", nand_we_n, 1);
    chk("R4", "oe_n idle", nand_oe_n, 1);
    chk("R6", "cle idle", nand_cle, 0);
    chk("R6", "ale idle", nand_ale, 0);
    chk("R5", "doe idle", nand_doe, 0);
    chk("R9", "ce_n kept", nand_ce_n, 0);
    if (!w) chk("R7", "rdata kept", rdata, rv & 8'hff);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req = 1'b0; wr = 1'b0; region = 2'b00; wdata = 8'h00;
    set_cyc = 8'd0; wait_cyc = 8'd0; hold_cyc = 8'd0; hiz_cyc = 8'd0;
    wait_en = 1'b0; other_bank = 1'b0; nand_din = 8'h00; nand_rdy = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "ce_n", nand_ce_n, 1);
    chk("R1", "we_n", nand_we_n, 1);
    chk("R1", "oe_n", nand_oe_n, 1);
    chk("R1", "cle", nand_cle, 0);
    chk("R1", "ale", nand_ale, 0);
    chk("R1", "doe", nand_doe, 0);
    chk("R1", "done", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ce_n after reset", nand_ce_n, 1);
    chk("R1", "done after reset", done, 0);

    do_acc(1'b1, 1, 8'h30, 0, 2, 3, 1, 4, 1'b0, 0, 1'b0);   // command write
    @(negedge clk);
    chk("R4", "done one cycle", done, 0);
    chk("R9", "ce_n between", nand_ce_n, 0);
    do_acc(1'b1, 2, 8'h5c, 0, 0, 0, 0, 0, 1'b0, 0, 1'b0);   // address write, all zero
    do_acc(1'b1, 0, 8'hc3, 0, 1, 1, 2, 20, 1'b0, 0, 1'b0);  // data write, long drive
    do_acc(1'b0, 0, 0, 8'ha5, 1, 2, 1, 0, 1'b1, 3, 1'b0);   // read with R8 stall
    do_acc(1'b1, 0, 8'h11, 0, 0, 1, 0, 1, 1'b0, 2, 1'b0);   // ready ignored, R8
    do_acc(1'b1, 3, 8'h7e, 0, 1, 0, 1, 2, 1'b0, 0, 1'b0);   // both bits: cle wins
    do_acc(1'b0, 2, 0, 8'h3c, 2, 1, 2, 5, 1'b0, 0, 1'b1);   // R10 noise during setup
    @(negedge clk);
    chk("R9", "ce_n still low", nand_ce_n, 0);
    other_bank = 1'b1;
    @(negedge clk);
    other_bank = 1'b0;
    chk("R9", "ce_n released", nand_ce_n, 1);
    @(negedge clk);
    chk("R9", "ce_n stays released", nand_ce_n, 1);
    do_acc(1'b0, 0, 0, 8'h96, 0, 4, 0, 0, 1'b1, 1, 1'b0);   // ce falls again
    @(negedge clk);
    chk("R4", "idle after done", done, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule